// File: doc/BRIEF.md
# Plasma Sub-Field Drive Sequencer

This block produces the per-frame timing strobes and electrode gate enables for a plasma panel driven with separate address and display periods. A frame start launches eight sub-fields in turn. Each sub-field runs three phases in fixed order. The reset phase is a Y ramp-up, then a Y ramp-down with the X bias enabled. The address phase is a line-at-a-time scan over every row. The sustain phase is an alternating Y/X pulse train. The number of pulses in that train doubles from one sub-field to the next, and the train always opens with a stretched pulse on Y.

All durations come in on plain configuration pins. The block captures them only while it is idle, so a running frame keeps its timing even if the configuration changes. A programmable dead time keeps any two electrode gate enables apart. Every interface is plain control: there is no streamed data and no handshake. A frame-start pulse is taken only while the block is idle, and no input ever back-pressures the sequencer.

Top module: `subfield_drive_seq`

## Requirements
- R1: A frame runs sub-fields 0 to 7 in order on `sf_index`. After the last one the block returns to idle, where `sf_index` reads 0.
- R2: Each sub-field drives `ph_reset`, then `ph_address`, then `ph_sustain`, with exactly one flag high while `busy`. The dead-time gap after a segment carries the flag of that segment's phase.
- R3: The reset phase holds `gate_y_rup` for `cfg_rampup_len` cycles, then a dead gap, then holds `gate_y_rdn` together with `x_bias_en` for `cfg_rampdn_len` cycles, then a dead gap.
- R4: The address phase gives each row from 0 to NUM_ROWS-1, in ascending order, a slot of `cfg_slot_len` cycles. In a slot, `latch_stb` is high in the first cycle and `scan_en` is high in the remaining cycles, and `row_idx` holds that row for the whole slot. `row_idx` reads 0 outside the address phase.
- R5: Sub-field k emits (`cfg_base_cnt` << k) sustain pulses.
- R6: Sustain pulses alternate between `gate_y_sus` and `gate_x_sus`, and the first pulse of every train is on `gate_y_sus`.
- R7: The first sustain pulse lasts `cfg_first_len` cycles and every later pulse lasts `cfg_pulse_len` cycles.
- R8: At most one of the four gate enables is high in any cycle. A gap of exactly `cfg_dead_len` cycles with no gate enable follows every ramp, every sustain pulse and the address phase.
- R9: A `frame_start` that arrives while `busy` is high has no effect on the running frame.
- R10: `frame_done` is high for exactly the first idle cycle after a frame. A `frame_start` sampled in that cycle starts a new frame.
- R11: The configuration pins are sampled only while idle. A change made during a frame applies from the next frame.
- R12: During and after reset the block is idle and every output is low or zero.
- R13: A length of 0 is treated as 1, a slot length below 2 is treated as 2, and a base count of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Starts a frame when idle |
| cfg_rampup_len | input | DUR_W | Y ramp-up length, cycles |
| cfg_rampdn_len | input | DUR_W | Y ramp-down length, cycles |
| cfg_slot_len | input | DUR_W | Scan slot length per row, cycles |
| cfg_pulse_len | input | DUR_W | Normal sustain pulse length, cycles |
| cfg_first_len | input | DUR_W | First sustain pulse length, cycles |
| cfg_dead_len | input | DUR_W | Dead time between enables, cycles |
| cfg_base_cnt | input | BASE_W | Sustain pulse count of sub-field 0 |
| busy | output | 1 | Frame in progress |
| ph_reset | output | 1 | Reset phase flag |
| ph_address | output | 1 | Address phase flag |
| ph_sustain | output | 1 | Sustain phase flag |
| sf_index | output | $clog2(NUM_SF) | Current sub-field |
| row_idx | output | $clog2(NUM_ROWS) | Row being scanned |
| latch_stb | output | 1 | Row data latch strobe |
| scan_en | output | 1 | Row scan enable |
| gate_y_rup | output | 1 | Y ramp-up gate enable |
| gate_y_rdn | output | 1 | Y ramp-down gate enable |
| x_bias_en | output | 1 | X bias during ramp-down |
| gate_x_sus | output | 1 | X sustain gate enable |
| gate_y_sus | output | 1 | Y sustain gate enable |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Every output is a Moore decode of the phase state, the timer and the row, pulse and sub-field counters. A wrong state or a miscounted counter therefore shows at the ports in the very cycle it occurs. It appears as a gate enable at the wrong time, a missing dead gap, a wrong row or sub-field number, or a train that ends one pulse early or late. The bench predicts the full output vector for every cycle of a frame from the configured lengths. A slip in any counter is caught in the first cycle that differs, and because the bench then stays out of step, the fault keeps showing in the cycles that follow.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RUP,
    ST_RUP_GAP,
    ST_RDN,
    ST_RDN_GAP,
    ST_ADDR,
    ST_ADDR_GAP,
    ST_SUS,
    ST_SUS_GAP
  } seq_state_t;

  typedef struct packed {
    logic y_rup;
    logic y_rdn;
    logic y_sus;
    logic x_sus;
  } gate_vec_t;
endpackage

// File: rtl/sfd_cfg_shadow.sv
module sfd_cfg_shadow #(
  parameter int DUR_W  = 16,
  parameter int BASE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic [DUR_W-1:0]  raw_up,
  input  logic [DUR_W-1:0]  raw_dn,
  input  logic [DUR_W-1:0]  raw_slot,
  input  logic [DUR_W-1:0]  raw_pulse,
  input  logic [DUR_W-1:0]  raw_first,
  input  logic [DUR_W-1:0]  raw_dead,
  input  logic [BASE_W-1:0] raw_base,
  output logic [DUR_W-1:0]  up_m1,
  output logic [DUR_W-1:0]  dn_m1,
  output logic [DUR_W-1:0]  slot_m1,
  output logic [DUR_W-1:0]  pulse_m1,
  output logic [DUR_W-1:0]  first_m1,
  output logic [DUR_W-1:0]  dead_m1,
  output logic [BASE_W-1:0] base_eff
);
  localparam int NLEN = 6;

  logic [DUR_W-1:0]  raw_len [NLEN];
  logic [DUR_W-1:0]  live_m1 [NLEN];
  logic [DUR_W-1:0]  held_m1 [NLEN];
  logic [DUR_W-1:0]  eff_m1  [NLEN];
  logic [BASE_W-1:0] live_base, held_base;

  assign raw_len[0] = raw_up;
  assign raw_len[1] = raw_dn;
  assign raw_len[2] = raw_slot;
  assign raw_len[3] = raw_pulse;
  assign raw_len[4] = raw_first;
  assign raw_len[5] = raw_dead;

  // R13: clamp lengths (slot needs two cycles: latch then scan)
  for (genvar g = 0; g < NLEN; g++) begin : g_len
    localparam int MINLEN = (g == 2) ? 2 : 1;
    always_comb begin
      if (raw_len[g] < DUR_W'(MINLEN)) live_m1[g] = DUR_W'(MINLEN - 1);
      else                             live_m1[g] = raw_len[g] - DUR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held_m1[g] <= '0;
      else if (idle) held_m1[g] <= live_m1[g];
    end

    // R11: live values pass through only while idle
    assign eff_m1[g] = idle ? live_m1[g] : held_m1[g];

    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && !$past(idle)) |-> $stable(held_m1[g]));
  end

  assign live_base = (raw_base == '0) ? BASE_W'(1) : raw_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_base <= BASE_W'(1);
    else if (idle) held_base <= live_base;
  end

  assign base_eff = idle ? live_base : held_base;
  assign up_m1    = eff_m1[0];
  assign dn_m1    = eff_m1[1];
  assign slot_m1  = eff_m1[2];
  assign pulse_m1 = eff_m1[3];
  assign first_m1 = eff_m1[4];
  assign dead_m1  = eff_m1[5];
endmodule

// File: rtl/sfd_phase_timer.sv
module sfd_phase_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - W'(1);
  end

  assign last = (cnt == '0);

  assert_timer_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $past(cnt) != '0) |-> (cnt == $past(cnt) - W'(1)));
endmodule

// File: rtl/sfd_gate_decode.sv
module sfd_gate_decode
  import sfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_t st,
  input  logic       pulse_odd,
  input  logic       slot_first,
  output gate_vec_t  gates,
  output logic       x_bias,
  output logic       ph_rst,
  output logic       ph_adr,
  output logic       ph_sus,
  output logic       busy,
  output logic       latch,
  output logic       scan
);
  always_comb begin
    gates       = '0;
    gates.y_rup = (st == ST_RUP);
    gates.y_rdn = (st == ST_RDN);
    gates.y_sus = (st == ST_SUS) && !pulse_odd;
    gates.x_sus = (st == ST_SUS) && pulse_odd;
  end

  assign x_bias = (st == ST_RDN);
  assign ph_rst = (st == ST_RUP) || (st == ST_RUP_GAP) || (st == ST_RDN) || (st == ST_RDN_GAP);
  assign ph_adr = (st == ST_ADDR) || (st == ST_ADDR_GAP);
  assign ph_sus = (st == ST_SUS) || (st == ST_SUS_GAP);
  assign busy   = (st != ST_IDLE);
  assign latch  = (st == ST_ADDR) && slot_first;
  assign scan   = (st == ST_ADDR) && !slot_first;

  assert_gate_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gates));

  assert_gate_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gates) != '0 && gates != '0) |-> (gates == $past(gates)));

  assert_latch_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan) |-> $past(latch));

  assert_phase_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot({ph_rst, ph_adr, ph_sus}));
endmodule

// File: rtl/subfield_drive_seq.sv
module subfield_drive_seq
  import sfd_pkg::*;
#(
  parameter int NUM_ROWS = 480,
  parameter int NUM_SF   = 8,
  parameter int DUR_W    = 16,
  parameter int BASE_W   = 4,
  localparam int ROW_W   = $clog2(NUM_ROWS),
  localparam int SF_W    = $clog2(NUM_SF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [DUR_W-1:0]  cfg_rampup_len,
  input  logic [DUR_W-1:0]  cfg_rampdn_len,
  input  logic [DUR_W-1:0]  cfg_slot_len,
  input  logic [DUR_W-1:0]  cfg_pulse_len,
  input  logic [DUR_W-1:0]  cfg_first_len,
  input  logic [DUR_W-1:0]  cfg_dead_len,
  input  logic [BASE_W-1:0] cfg_base_cnt,
  output logic              busy,
  output logic              ph_reset,
  output logic              ph_address,
  output logic              ph_sustain,
  output logic [SF_W-1:0]   sf_index,
  output logic [ROW_W-1:0]  row_idx,
  output logic              latch_stb,
  output logic              scan_en,
  output logic              gate_y_rup,
  output logic              gate_y_rdn,
  output logic              x_bias_en,
  output logic              gate_x_sus,
  output logic              gate_y_sus,
  output logic              frame_done
);
  localparam int PC_W = BASE_W + NUM_SF - 1;
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);
  localparam logic [SF_W-1:0]  SF_LAST  = SF_W'(NUM_SF - 1);

  seq_state_t        st, st_nx;
  logic [SF_W-1:0]   sf_q;
  logic [ROW_W-1:0]  row_q;
  logic [PC_W-1:0]   pulse_q, pulse_span, pulse_end;
  logic              done_q;

  logic [DUR_W-1:0]  up_m1, dn_m1, slot_m1, pulse_m1, first_m1, dead_m1;
  logic [BASE_W-1:0] base_eff;

  logic              tmr_load, tmr_last;
  logic [DUR_W-1:0]  tmr_val, tmr_cnt;

  logic              train_end, frame_end, row_end;
  gate_vec_t         gates;

  sfd_cfg_shadow #(.DUR_W(DUR_W), .BASE_W(BASE_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .idle(st == ST_IDLE),
    .raw_up(cfg_rampup_len), .raw_dn(cfg_rampdn_len), .raw_slot(cfg_slot_len),
    .raw_pulse(cfg_pulse_len), .raw_first(cfg_first_len), .raw_dead(cfg_dead_len),
    .raw_base(cfg_base_cnt),
    .up_m1(up_m1), .dn_m1(dn_m1), .slot_m1(slot_m1), .pulse_m1(pulse_m1),
    .first_m1(first_m1), .dead_m1(dead_m1), .base_eff(base_eff)
  );

  sfd_phase_timer #(.W(DUR_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .cnt(tmr_cnt), .last(tmr_last)
  );

  // R5: binary-weighted pulse count per sub-field
  assign pulse_span = PC_W'(base_eff) << sf_q;
  assign pulse_end  = pulse_span - PC_W'(1);
  assign train_end  = (pulse_q == pulse_end);
  assign frame_end  = train_end && (sf_q == SF_LAST);
  assign row_end    = (row_q == ROW_LAST);

  always_comb begin
    st_nx    = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st)
      ST_IDLE: if (frame_start) begin
        st_nx = ST_RUP; tmr_load = 1'b1; tmr_val = up_m1;
      end
      ST_RUP: if (tmr_last) begin
        st_nx = ST_RUP_GAP; tmr_load = 1'b1; tmr_val = dead_m1;
      end
      ST_RUP_GAP: if (tmr_last) begin
        st_nx = ST_RDN; tmr_load = 1'b1; tmr_val = dn_m1;
      end
      ST_RDN: if (tmr_last) begin
        st_nx = ST_RDN_GAP; tmr_load = 1'b1; tmr_val = dead_m1;
      end
      ST_RDN_GAP: if (tmr_last) begin
        st_nx = ST_ADDR; tmr_load = 1'b1; tmr_val = slot_m1;
      end
      ST_ADDR: if (tmr_last) begin
        tmr_load = 1'b1;
        if (row_end) begin
          st_nx = ST_ADDR_GAP; tmr_val = dead_m1;
        end else begin
          tmr_val = slot_m1;
        end
      end
      ST_ADDR_GAP: if (tmr_last) begin
        st_nx = ST_SUS; tmr_load = 1'b1; tmr_val = first_m1;
      end
      ST_SUS: if (tmr_last) begin
        st_nx = ST_SUS_GAP; tmr_load = 1'b1; tmr_val = dead_m1;
      end
      ST_SUS_GAP: if (tmr_last) begin
        if (frame_end) begin
          st_nx = ST_IDLE;
        end else if (train_end) begin
          st_nx = ST_RUP; tmr_load = 1'b1; tmr_val = up_m1;
        end else begin
          st_nx = ST_SUS; tmr_load = 1'b1; tmr_val = pulse_m1;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sf_q    <= '0;
      row_q   <= '0;
      pulse_q <= '0;
      done_q  <= 1'b0;
    end else begin
      st     <= st_nx;
      done_q <= (st == ST_SUS_GAP) && tmr_last && frame_end;
      if (st == ST_SUS_GAP && tmr_last && train_end)
        sf_q <= frame_end ? '0 : sf_q + SF_W'(1);
      if (st == ST_ADDR && tmr_last)
        row_q <= row_end ? '0 : row_q + ROW_W'(1);
      if (st == ST_ADDR_GAP && tmr_last)
        pulse_q <= '0;
      else if (st == ST_SUS_GAP && tmr_last && !train_end)
        pulse_q <= pulse_q + PC_W'(1);
    end
  end

  sfd_gate_decode dec_i (
    .clk(clk), .rst_n(rst_n), .st(st), .pulse_odd(pulse_q[0]),
    .slot_first(tmr_cnt == slot_m1),
    .gates(gates), .x_bias(x_bias_en),
    .ph_rst(ph_reset), .ph_adr(ph_address), .ph_sus(ph_sustain),
    .busy(busy), .latch(latch_stb), .scan(scan_en)
  );

  assign gate_y_rup = gates.y_rup;
  assign gate_y_rdn = gates.y_rdn;
  assign gate_y_sus = gates.y_sus;
  assign gate_x_sus = gates.x_sus;
  assign sf_index   = sf_q;
  assign row_idx    = row_q;
  assign frame_done = done_q;

  assert_sf_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_q != $past(sf_q)) |-> (sf_q == $past(sf_q) + SF_W'(1) || sf_q == '0));

  assert_row_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= ROW_LAST);

  assert_sus_first_y_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_sustain) |-> gate_y_sus);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (!frame_done && (busy || st == ST_IDLE)));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frame_start && !$rose(busy)) |=> !$rose(gate_y_rup) || $past(st) == ST_SUS_GAP);
endmodule

// File: tb/subfield_drive_seq_tb_top.sv
`timescale 1ns/1ps
module subfield_drive_seq_tb_top;
  localparam int ROWS  = 4;
  localparam int NSF   = 8;
  localparam int DW    = 8;
  localparam int BW    = 2;
  localparam int VW    = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [DW-1:0] c_up, c_dn, c_slot, c_pulse, c_first, c_dead;
  logic [BW-1:0] c_base;

  logic busy, ph_r, ph_a, ph_s, latch, scan, g_rup, g_rdn, xb, gx, gy, done;
  logic [2:0] sf;
  logic [1:0] row;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  subfield_drive_seq #(.NUM_ROWS(ROWS), .NUM_SF(NSF), .DUR_W(DW), .BASE_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_rampup_len(c_up), .cfg_rampdn_len(c_dn), .cfg_slot_len(c_slot),
    .cfg_pulse_len(c_pulse), .cfg_first_len(c_first), .cfg_dead_len(c_dead),
    .cfg_base_cnt(c_base),
    .busy(busy), .ph_reset(ph_r), .ph_address(ph_a), .ph_sustain(ph_s),
    .sf_index(sf), .row_idx(row), .latch_stb(latch), .scan_en(scan),
    .gate_y_rup(g_rup), .gate_y_rdn(g_rdn), .x_bias_en(xb),
    .gate_x_sus(gx), .gate_y_sus(gy), .frame_done(done)
  );

  // vector: busy ph_r ph_a ph_s sf[3] row[2] latch scan rup rdn xb gx gy done
  function automatic logic [VW-1:0] ev(logic b, logic pr, logic pa, logic ps,
      logic [2:0] s, logic [1:0] r, logic la, logic sc, logic ru, logic rd,
      logic x, logic ex, logic ey, logic dn);
    return {b, pr, pa, ps, s, r, la, sc, ru, rd, x, ex, ey, dn};
  endfunction

  function automatic logic [VW-1:0] act();
    return {busy, ph_r, ph_a, ph_s, sf, row, latch, scan, g_rup, g_rdn, xb, gx, gy, done};
  endfunction

  task automatic chk(logic [VW-1:0] exp, string tag);
    n_checks++;
    if (act() !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act(), exp);
    end
  endtask

  task automatic hold(int n, logic [VW-1:0] exp, string tag);
    for (int i = 0; i < n; i++) begin
      chk(exp, tag);
      @(negedge clk);
    end
  endtask

  // Called at the negedge of the first ramp-up cycle; returns at the done cycle.
  task automatic run_frame(int up, int dn, int slot, int pl, int fst, int dd, int base);
    for (int s = 0; s < NSF; s++) begin
      logic [2:0] k = 3'(s);
      int npulse = base << s;
      hold(up, ev(1,1,0,0,k,0,0,0,1,0,0,0,0,0), "R3 rampup");
      hold(dd, ev(1,1,0,0,k,0,0,0,0,0,0,0,0,0), "R8 gap after rampup");
      hold(dn, ev(1,1,0,0,k,0,0,0,0,1,1,0,0,0), "R3 rampdown");
      hold(dd, ev(1,1,0,0,k,0,0,0,0,0,0,0,0,0), "R8 gap after rampdown");
      for (int r = 0; r < ROWS; r++) begin
        hold(1, ev(1,0,1,0,k,2'(r),1,0,0,0,0,0,0,0), "R4 latch");
        hold(slot - 1, ev(1,0,1,0,k,2'(r),0,1,0,0,0,0,0,0), "R4 scan");
      end
      hold(dd, ev(1,0,1,0,k,0,0,0,0,0,0,0,0,0), "R2 R8 gap after address");
      for (int p = 0; p < npulse; p++) begin
        logic odd = p[0];
        hold((p == 0) ? fst : pl, ev(1,0,0,1,k,0,0,0,0,0,0,odd,!odd,0), "R5 R6 R7 sustain");
        hold(dd, ev(1,0,0,1,k,0,0,0,0,0,0,0,0,0), "R5 R8 sustain gap");
      end
    end
    chk(ev(0,0,0,0,0,0,0,0,0,0,0,0,0,1), "R1 R10 done");
  endtask

  task automatic set_cfg(int up, int dn, int slot, int pl, int fst, int dd, int base);
    c_up = DW'(up); c_dn = DW'(dn); c_slot = DW'(slot);
    c_pulse = DW'(pl); c_first = DW'(fst); c_dead = DW'(dd); c_base = BW'(base);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    set_cfg(3, 2, 3, 1, 3, 1, 1);
    repeat (3) @(negedge clk);
    chk('0, "R12 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    hold(3, '0, "R12 idle after reset");

    // Frame A
    frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
    run_frame(3, 2, 3, 1, 3, 1, 1);
    @(negedge clk);
    hold(2, '0, "R10 done single cycle");

    // Frame B with mid-frame start and config change (R9, R11)
    set_cfg(1, 1, 2, 2, 4, 2, 2);
    frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
    fork
      run_frame(1, 1, 2, 2, 4, 2, 2);
      begin
        repeat (40) @(negedge clk);
        frame_start = 1'b1;             // R9: ignored while busy
        @(negedge clk);
        frame_start = 1'b0;
        set_cfg(0, 0, 0, 0, 0, 0, 0);   // R11: applies next frame
      end
    join

    // Back-to-back start in the done cycle: frame C with clamped zeros (R10, R13)
    frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
    run_frame(1, 1, 2, 1, 1, 1, 1);
    @(negedge clk);
    hold(2, '0, "R10 idle after frame C");

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule